// File: doc/BRIEF.md
# Four-Port Configurable GPIO Controller

This block runs four 8-bit general-purpose I/O ports from one shared configuration byte. Each port has a 2-bit field in that byte, and the field sets two things at once: how the port's pins are driven and which edge direction raises an interrupt. For every pin the block produces three pad controls: drive enable, drive value and pull-up enable. They depend on the port's mode, the pin's written data bit and the pin's interrupt-mask bit. In the actively driven mode the mask bits have a second use and act as per-pin direction selects.

Pad inputs pass through a two-flop synchroniser. The block then compares each synchronised level with the level one cycle earlier. A qualifying edge on an armed pin sets a sticky pending bit, and the interrupt request is the OR of all pending bits. Software reaches the block through a simple register bus. A write can target the configuration byte, a port's data register, a port's mask register or the clear address. A read returns the configuration byte, the synchronised pin levels of a port, or a port's mask.

Each port's field is decoded into one of four named modes: `MODE_OD_RISE` (00), `MODE_OD_FALL` (01), `MODE_PULLUP` (10) and `MODE_PUSHPULL` (11). The mode changes only when software writes the configuration byte, and any mode can change directly to any other.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0, every data register holds all ones, every mask is 0, and irq is 0. In this state no pin is driven and no pull-up is on.
- R2: Port p takes its mode from configuration bits [2p+1:2p]. Field code 11 selects push-pull, 10 selects pull-up, 01 selects open drain with falling-edge interrupts, and 00 selects open drain with rising-edge interrupts.
- R3: In push-pull mode, a pin whose mask bit is 0 is driven with drive value equal to its data bit. A pin whose mask bit is 1 behaves as open drain: it is driven low when its data bit is 0 and undriven when its data bit is 1. The pull-up is always off in this mode.
- R4: In pull-up mode, a pin whose data bit is 1 has its pull-up on and is not driven. A pin whose data bit is 0 is driven low with its pull-up off.
- R5: In both open-drain modes the pull-up is off. A pin whose data bit is 0 is driven low, and a pin whose data bit is 1 is undriven. The drive value is 0 in every mode except push-pull.
- R6: Only pins whose mask bit is 1 can interrupt. In mode 00 they interrupt on a rising edge, and in modes 01 and 10 they interrupt on a falling edge. An edge in the other direction has no effect on irq.
- R7: A port in push-pull mode never sets a pending bit, whatever its mask bits and pad activity.
- R8: A pad change shows up in the port data read after the second rising clock edge. If the change qualifies as an interrupt, irq rises after the third edge.
- R9: Pending bits are sticky. Only a write to address 9 clears them (the write data is ignored). If an edge is detected in the same cycle as the clear, the new pending bit is kept.
- R10: Writing the configuration byte or a mask never produces an interrupt by itself. A pin level that has been steady for three or more cycles produces no edge.
- R11: The register map is as follows. Address 0 is the configuration byte. Address 1+p is port p's data: writes go to the data register, and reads return the synchronised pin levels. Address 5+p is port p's mask. Address 9 is the clear. All other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pad levels, pin index port*8+bit |
| pad_drv_en | output | 32 | Pad output driver enable |
| pad_drv_val | output | 32 | Level driven when enabled |
| pad_pu_en | output | 32 | Pull-up enable |
| irq | output | 1 | OR of all pending bits |

## Verification
Two cases are the hardest to reach from the ports. One is a clear write that lands on the exact edge where a new pending bit is set. The other is a mode or mask change made while a pin sits at a level that would look like an edge if the old level had not been tracked. Directed sequences time the pad change from a negative clock edge, so that the third rising edge coincides with the clear write. They also park a pin low while it is unarmed and only then arm it or flip its polarity. A long pseudo-random phase then mixes register writes and pad toggles, and a behavioural model is compared against the design on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        MODE_OD_RISE  = 2'b00,
        MODE_OD_FALL  = 2'b01,
        MODE_PULLUP   = 2'b10,
        MODE_PUSHPULL = 2'b11
    } port_mode_e;

    function automatic int data_addr(input int port);
        return 1 + port;
    endfunction

    function automatic int mask_addr(input int nport, input int port);
        return 1 + nport + port;
    endfunction

    function automatic int clr_addr(input int nport);
        return 1 + 2 * nport;
    endfunction

endpackage

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
    import gpio_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int PW    = 8,
    parameter int AW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [PW-1:0]         bus_wdata,
    input  logic [NPORT*PW-1:0]   pin_lvl,
    output logic [2*NPORT-1:0]    cfg_q,
    output logic [NPORT*PW-1:0]   dat_q,
    output logic [NPORT*PW-1:0]   msk_q,
    output logic                  clr_pulse,
    output logic [PW-1:0]         bus_rdata
);
    localparam int CW = 2 * NPORT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dat_q <= '1;
            msk_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == AW'(0))
                cfg_q <= bus_wdata[CW-1:0];
            for (int p = 0; p < NPORT; p++) begin
                if (bus_addr == AW'(data_addr(p)))
                    dat_q[p*PW +: PW] <= bus_wdata;
                if (bus_addr == AW'(mask_addr(NPORT, p)))
                    msk_q[p*PW +: PW] <= bus_wdata;
            end
        end
    end

    assign clr_pulse = bus_wr && (bus_addr == AW'(clr_addr(NPORT)));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(0))
            bus_rdata = PW'(cfg_q);
        for (int p = 0; p < NPORT; p++) begin
            if (bus_addr == AW'(data_addr(p)))
                bus_rdata = pin_lvl[p*PW +: PW];
            if (bus_addr == AW'(mask_addr(NPORT, p)))
                bus_rdata = msk_q[p*PW +: PW];
        end
    end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
#(
    parameter int PW = 8
) (
    input  port_mode_e     mode,
    input  logic [PW-1:0]  dat,
    input  logic [PW-1:0]  msk,
    output logic [PW-1:0]  drv_en,
    output logic [PW-1:0]  drv_val,
    output logic [PW-1:0]  pu_en
);
    always_comb begin
        unique case (mode)
            MODE_PUSHPULL: begin
                drv_en  = ~msk | ~dat;
                drv_val = ~msk & dat;
                pu_en   = '0;
            end
            MODE_PULLUP: begin
                drv_en  = ~dat;
                drv_val = '0;
                pu_en   = dat;
            end
            MODE_OD_RISE, MODE_OD_FALL: begin
                drv_en  = ~dat;
                drv_val = '0;
                pu_en   = '0;
            end
            default: begin
                drv_en  = '0;
                drv_val = '0;
                pu_en   = '0;
            end
        endcase
    end

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
    import gpio_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PW-1:0]  pad,
    input  port_mode_e     mode,
    input  logic [PW-1:0]  msk,
    input  logic           clr,
    output logic [PW-1:0]  lvl,
    output logic [PW-1:0]  pend
);
    logic [PW-1:0] sync_a;
    logic [PW-1:0] sync_b;
    logic [PW-1:0] last_q;
    logic [PW-1:0] armed;
    logic [PW-1:0] hit;

    always_comb begin
        armed = (mode == MODE_PUSHPULL) ? '0 : msk;
        unique case (mode)
            MODE_OD_RISE: hit = armed & sync_b & ~last_q;
            default:      hit = armed & ~sync_b & last_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            last_q <= '0;
            pend   <= '0;
        end else begin
            sync_a <= pad;
            sync_b <= sync_a;
            last_q <= sync_b;
            pend   <= (clr ? '0 : pend) | hit;
        end
    end

    assign lvl = sync_b;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int PW    = 8,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [PW-1:0]        bus_wdata,
    output logic [PW-1:0]        bus_rdata,
    input  logic [NPORT*PW-1:0]  pad_in,
    output logic [NPORT*PW-1:0]  pad_drv_en,
    output logic [NPORT*PW-1:0]  pad_drv_val,
    output logic [NPORT*PW-1:0]  pad_pu_en,
    output logic                 irq
);
    localparam int NPIN = NPORT * PW;
    localparam int CW   = 2 * NPORT;

    logic [CW-1:0]   cfg_q;
    logic [NPIN-1:0] dat_q;
    logic [NPIN-1:0] msk_q;
    logic [NPIN-1:0] pin_lvl;
    logic [NPIN-1:0] pend;
    logic            clr_pulse;

    gpio_bus_regs #(.NPORT(NPORT), .PW(PW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_lvl   (pin_lvl),
        .cfg_q     (cfg_q),
        .dat_q     (dat_q),
        .msk_q     (msk_q),
        .clr_pulse (clr_pulse),
        .bus_rdata (bus_rdata)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_mode_e mode;
        assign mode = port_mode_e'(cfg_q[2*p +: 2]);

        gpio_pad_drive #(.PW(PW)) u_drive (
            .mode    (mode),
            .dat     (dat_q[p*PW +: PW]),
            .msk     (msk_q[p*PW +: PW]),
            .drv_en  (pad_drv_en[p*PW +: PW]),
            .drv_val (pad_drv_val[p*PW +: PW]),
            .pu_en   (pad_pu_en[p*PW +: PW])
        );

        gpio_edge_unit #(.PW(PW)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pad   (pad_in[p*PW +: PW]),
            .mode  (mode),
            .msk   (msk_q[p*PW +: PW]),
            .clr   (clr_pulse),
            .lvl   (pin_lvl[p*PW +: PW]),
            .pend  (pend[p*PW +: PW])
        );
    end

    assign irq = |pend;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int PW    = 8,
    parameter int AW    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [2*NPORT-1:0]   cfg_q,
    input logic [NPORT*PW-1:0]  pad_drv_en,
    input logic [NPORT*PW-1:0]  pad_drv_val,
    input logic [NPORT*PW-1:0]  pad_pu_en,
    input logic                 irq
);
    localparam logic [AW-1:0] CLR_A = AW'(clr_addr(NPORT));

    // R9: pending state survives every cycle without a clear write
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && bus_addr == CLR_A)) |=> irq);

    // R7: with every port push-pull, no new request can appear
    p_pushpull_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cfg_q) && !irq) |=> !irq);

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        logic [1:0] m;
        assign m = cfg_q[2*p +: 2];

        // R4: a pulled-up pin is never also driven
        p_pull_excl_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_pu_en[p*PW +: PW] & pad_drv_en[p*PW +: PW]) == '0);

        // R4: pull-up mode only ever sinks
        p_pullup_sinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b10) |-> (pad_drv_val[p*PW +: PW] == '0));

        // R5: open drain has no pull-up and drives only low
        p_od_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (m[1] == 1'b0) |-> (pad_pu_en[p*PW +: PW] == '0 && pad_drv_val[p*PW +: PW] == '0));

        // R3: push-pull never enables a pull-up
        p_pushpull_no_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b11) |-> (pad_pu_en[p*PW +: PW] == '0));
    end

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPORT(NPORT), .PW(PW), .AW(AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .cfg_q       (cfg_q),
    .pad_drv_en  (pad_drv_en),
    .pad_drv_val (pad_drv_val),
    .pad_pu_en   (pad_pu_en),
    .irq         (irq)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pad_in = '1;
    logic [31:0] pad_drv_en;
    logic [31:0] pad_drv_val;
    logic [31:0] pad_pu_en;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_drv_en(pad_drv_en), .pad_drv_val(pad_drv_val),
        .pad_pu_en(pad_pu_en), .irq(irq)
    );

    // behavioural reference model
    bit [7:0]  m_cfg;
    bit [7:0]  m_dat [4];
    bit [7:0]  m_msk [4];
    bit [31:0] m_s1, m_s2, m_prev, m_pend;

    always @(posedge clk) begin
        bit [31:0] hits;
        int md;
        if (!rst_n) begin
            m_cfg = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
            for (int p = 0; p < 4; p++) begin m_dat[p] = 8'hFF; m_msk[p] = 0; end
        end else begin
            hits = 0;
            for (int i = 0; i < 32; i++) begin
                md = (m_cfg >> (2 * (i / 8))) & 3;
                if (md != 3 && m_msk[i / 8][i % 8]) begin
                    if (md == 0 && m_s2[i] && !m_prev[i]) hits[i] = 1'b1;
                    if (md != 0 && !m_s2[i] && m_prev[i]) hits[i] = 1'b1;
                end
            end
            if (bus_wr && bus_addr == 4'd9) m_pend = 0;
            m_pend = m_pend | hits;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            if (bus_wr) begin
                if (bus_addr == 0) m_cfg = bus_wdata;
                else if (bus_addr >= 1 && bus_addr <= 4) m_dat[bus_addr - 1] = bus_wdata;
                else if (bus_addr >= 5 && bus_addr <= 8) m_msk[bus_addr - 5] = bus_wdata;
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    initial forever begin
        bit [31:0] e_en, e_val, e_pu;
        bit [7:0]  e_rd;
        int md;
        bit d, k;
        @(posedge clk); #3;
        if (!done) begin
            for (int i = 0; i < 32; i++) begin
                md = (m_cfg >> (2 * (i / 8))) & 3;
                d = m_dat[i / 8][i % 8];
                k = m_msk[i / 8][i % 8];
                e_en[i] = (md == 3 && !k) ? 1'b1 : !d;
                e_val[i] = (md == 3 && !k) ? d : 1'b0;
                e_pu[i] = (md == 2) ? d : 1'b0;
            end
            e_rd = 0;
            if (bus_addr == 0) e_rd = m_cfg;
            else if (bus_addr >= 1 && bus_addr <= 4) e_rd = m_s2[8 * (bus_addr - 1) +: 8];
            else if (bus_addr >= 5 && bus_addr <= 8) e_rd = m_msk[bus_addr - 5];
            check("R3 R4 R5 model drive enable", 64'(pad_drv_en), 64'(e_en));
            check("R3 R5 model drive value", 64'(pad_drv_val), 64'(e_val));
            check("R4 R5 model pull-up", 64'(pad_pu_en), 64'(e_pu));
            check("R11 model read data", 64'(bus_rdata), 64'(e_rd));
            check("R6 R8 R9 model irq", 64'(irq), 64'(m_pend != 0));
        end
    end

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        int unsigned r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 drive enable after reset", 64'(pad_drv_en), 64'h0);
        check("R1 pull-up after reset", 64'(pad_pu_en), 64'h0);
        check("R1 irq after reset", 64'(irq), 64'h0);
        rd_chk("R1 config reads zero", 4'd0, 8'h00);

        do_wr(4'd0, 8'h1B);
        do_wr(4'd1, 8'hA5);
        do_wr(4'd5, 8'h0F);
        do_wr(4'd2, 8'h3C);
        do_wr(4'd3, 8'h0F);
        #1;
        check("R3 push-pull enables", 64'(pad_drv_en[7:0]), 64'hFA);
        check("R3 push-pull values", 64'(pad_drv_val[7:0]), 64'hA0);
        check("R4 pull-up enables", 64'(pad_pu_en[15:8]), 64'h3C);
        check("R4 pull-up low drive", 64'(pad_drv_en[15:8]), 64'hC3);
        check("R5 open drain enables", 64'(pad_drv_en[23:16]), 64'hF0);
        check("R5 open drain no pull-up", 64'(pad_pu_en[31:16]), 64'h0);

        rd_chk("R11 config readback", 4'd0, 8'h1B);
        rd_chk("R11 mask readback", 4'd5, 8'h0F);
        rd_chk("R11 data reads pin levels", 4'd2, 8'hFF);
        rd_chk("R11 clear address reads zero", 4'd9, 8'h00);
        rd_chk("R11 unused address reads zero", 4'd12, 8'h00);

        do_wr(4'd0, 8'hC0);
        #1;
        check("R2 port3 field selects push-pull", 64'(pad_drv_en[31:24]), 64'hFF);
        check("R2 port0 field now open drain", 64'(pad_drv_en[7:0]), 64'h5A);
        do_wr(4'd0, 8'h1B);

        // R8 latency on port2 (falling, all armed)
        do_wr(4'd7, 8'hFF);
        do_wr(4'd9, 8'h00);
        #1;
        check("R9 cleared before latency test", 64'(irq), 64'h0);
        @(negedge clk);
        bus_addr = 4'd3;
        pad_in[16] = 1'b0;
        @(posedge clk); #3;
        check("R8 level after one edge", 64'(bus_rdata), 64'hFF);
        @(posedge clk); #3;
        check("R8 level after two edges", 64'(bus_rdata), 64'hFE);
        check("R8 irq not yet", 64'(irq), 64'h0);
        @(posedge clk); #3;
        check("R8 irq after three edges", 64'(irq), 64'h1);

        settle(5);
        check("R9 irq sticky", 64'(irq), 64'h1);
        @(negedge clk);
        pad_in[17] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd9;
        @(posedge clk); #3;
        check("R9 new edge wins over clear", 64'(irq), 64'h1);
        @(negedge clk);
        bus_wr = 1'b0;
        settle(3);
        check("R9 kept after clear", 64'(irq), 64'h1);
        do_wr(4'd9, 8'h55);
        #1;
        check("R9 clear write", 64'(irq), 64'h0);

        // R10 no false edges on port3
        @(negedge clk);
        pad_in[24] = 1'b0;
        settle(4);
        do_wr(4'd8, 8'h01);
        settle(4);
        check("R10 arming a low pin", 64'(irq), 64'h0);
        do_wr(4'd0, 8'h5B);
        settle(4);
        check("R10 polarity change on steady pin", 64'(irq), 64'h0);
        pad_in[24] = 1'b1;
        settle(4);
        check("R6 falling mode ignores rise", 64'(irq), 64'h0);
        pad_in[24] = 1'b0;
        settle(4);
        check("R6 falling mode fall", 64'(irq), 64'h1);
        do_wr(4'd9, 8'h00);
        do_wr(4'd0, 8'h1B);
        pad_in[24] = 1'b1;
        settle(4);
        check("R6 rising mode rise", 64'(irq), 64'h1);
        do_wr(4'd9, 8'h00);
        pad_in[24] = 1'b0;
        settle(4);
        check("R6 rising mode ignores fall", 64'(irq), 64'h0);
        pad_in[25] = 1'b0;
        settle(4);
        pad_in[25] = 1'b1;
        settle(4);
        check("R6 unmasked pin ignored", 64'(irq), 64'h0);
        do_wr(4'd6, 8'h01);
        pad_in[8] = 1'b0;
        settle(4);
        check("R6 pull-up mode falling edge", 64'(irq), 64'h1);
        do_wr(4'd9, 8'h00);

        // R7 push-pull port0 with mask 0x0F
        pad_in[0] = 1'b0;
        settle(4);
        pad_in[0] = 1'b1;
        settle(4);
        check("R7 push-pull port silent", 64'(irq), 64'h0);

        r = 32'h1234_5678;
        for (int n = 0; n < 3000; n++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            @(negedge clk);
            if (r[3:0] < 4'd3) begin
                bus_wr = 1'b1;
                bus_addr = 4'(int'(r[7:4]) % 11);
                bus_wdata = r[15:8];
            end else begin
                bus_wr = 1'b0;
                bus_addr = 4'(int'(r[27:24]) % 11);
            end
            if (r[21]) pad_in = pad_in ^ (32'd1 << r[20:16]);
        end
        @(negedge clk);
        bus_wr = 1'b0;
        settle(5);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule